// File: doc/BRIEF.md
# ADC Trigger and Transfer Controller

This block sequences one analogue-to-digital conversion per trigger pulse and hands the result to a serial transmitter. A mode input chooses the trigger source: a periodic timer pulse or a debounced manual pulse. Once triggered, the controller runs a register-read handshake with the converter. It starts a conversion, waits for end of conversion, issues a read, and waits for the data-ready flag.

After data ready, the controller keeps the upper part of the converter word in a data register. It then raises a write strobe for exactly one clock so that a transmitter can load the value. Triggers that arrive while a transfer is in progress are not queued; they are dropped. The converter, the timer and the debouncer are outside this block.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted and in the first cycle after it, data_out reads 0 and conv_start, rd_en and write_stb are low.
- R2: With auto_sel high, a timer_pulse starts a transfer and a manual_pulse has no effect: no conv_start follows, and data_out keeps its value.
- R3: With auto_sel low, a manual_pulse starts a transfer and a timer_pulse has no effect: no conv_start follows, and data_out keeps its value.
- R4: A selected trigger that is high at a clock edge while the controller is idle produces conv_start high for exactly one clock, in the cycle after that edge.
- R5: eoc high at an edge while the controller waits for conversion end produces rd_en high for exactly one clock, in the next cycle.
- R6: data_out takes bits [15:4] of rd_word (RAW_W-1 down to RAW_W-OUT_W) as sampled in the capture state. It holds that value until the next capture or reset.
- R7: write_stb is high for exactly one clock, two cycles after the cycle in which drdy is high. data_out already shows the new value while write_stb is high. There is exactly one write_stb per accepted trigger.
- R8: Trigger pulses that arrive between an accepted trigger and the end of its write_stb are ignored and produce no extra conv_start.
- R9: A reset in the middle of a transfer aborts it. No write_stb follows, and data_out reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_sel | input | 1 | 1 selects timer_pulse, 0 selects manual_pulse |
| timer_pulse | input | 1 | Periodic trigger pulse |
| manual_pulse | input | 1 | Debounced push-button trigger pulse |
| conv_start | output | 1 | One-clock conversion start to the converter |
| eoc | input | 1 | End of conversion from the converter |
| rd_en | output | 1 | One-clock read request to the converter |
| drdy | input | 1 | Read data ready from the converter |
| rd_word | input | RAW_W (16) | Converter read word |
| data_out | output | OUT_W (12) | Captured upper bits of the read word |
| write_stb | output | 1 | One-clock load strobe for the transmitter |

## Verification
Each state of the machine drives a distinct output or waits on a distinct input, so a wrong state shows at the ports within one handshake step. It can appear as a missing or doubled conv_start or rd_en, as a write_stb at the wrong offset from drdy, or as a transfer that never ends. A wrong capture slice or wrong capture timing shows on data_out in the same cycle as write_stb. The bench therefore measures the cycle offsets of every strobe and compares the data word on each transfer, over a sweep of read words in both trigger modes. It also fires unselected, busy-time and reset-time stimuli and watches the strobes for changes.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_START     = 3'd1,
        ST_WAIT_EOC  = 3'd2,
        ST_READ      = 3'd3,
        ST_WAIT_RDY  = 3'd4,
        ST_CAPTURE   = 3'd5,
        ST_XMIT      = 3'd6
    } xfer_state_t;

    typedef struct packed {
        xfer_state_t st;
    } fsm_regs_t;

endpackage

// File: rtl/adc_trig_select.sv
module adc_trig_select (
    input  logic auto_sel,
    input  logic timer_pulse,
    input  logic manual_pulse,
    output logic trig
);

    always_comb begin
        trig = auto_sel ? timer_pulse : manual_pulse;
    end

endmodule

// File: rtl/adc_xfer_fsm.sv
module adc_xfer_fsm
    import adc_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic eoc,
    input  logic drdy,
    output logic conv_start,
    output logic rd_en,
    output logic capture,
    output logic write_stb
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE:     if (trig) r_d.st = ST_START;
            ST_START:    r_d.st = ST_WAIT_EOC;
            ST_WAIT_EOC: if (eoc)  r_d.st = ST_READ;
            ST_READ:     r_d.st = ST_WAIT_RDY;
            ST_WAIT_RDY: if (drdy) r_d.st = ST_CAPTURE;
            ST_CAPTURE:  r_d.st = ST_XMIT;
            ST_XMIT:     r_d.st = ST_IDLE;
            default:     r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.st <= ST_IDLE;
        else     r_q    <= r_d;
    end

    // Moore outputs decoded from the present state
    always_comb begin
        conv_start = (r_q.st == ST_START);
        rd_en      = (r_q.st == ST_READ);
        capture    = (r_q.st == ST_CAPTURE);
        write_stb  = (r_q.st == ST_XMIT);
    end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RAW_W = 16,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RAW_W-1:0] word_in,
    output logic [OUT_W-1:0] data_q
);

    localparam int LSB = RAW_W - OUT_W;

    logic [OUT_W-1:0] slice;
    logic [OUT_W-1:0] data_d;

    generate
        if (LSB > 0) begin : g_trim
            logic unused_low;
            assign unused_low = ^word_in[LSB-1:0];
            assign slice      = word_in[RAW_W-1:LSB];
        end else begin : g_full
            assign slice = word_in[OUT_W-1:0];
        end
    endgenerate

    always_comb begin
        data_d = data_q;
        if (load) data_d = slice;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end

endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl #(
    parameter int RAW_W = 16,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_sel,
    input  logic             timer_pulse,
    input  logic             manual_pulse,
    output logic             conv_start,
    input  logic             eoc,
    output logic             rd_en,
    input  logic             drdy,
    input  logic [RAW_W-1:0] rd_word,
    output logic [OUT_W-1:0] data_out,
    output logic             write_stb
);

    logic trig;
    logic capture;

    adc_trig_select i_sel (
        .auto_sel     (auto_sel),
        .timer_pulse  (timer_pulse),
        .manual_pulse (manual_pulse),
        .trig         (trig)
    );

    adc_xfer_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .eoc        (eoc),
        .drdy       (drdy),
        .conv_start (conv_start),
        .rd_en      (rd_en),
        .capture    (capture),
        .write_stb  (write_stb)
    );

    adc_result_reg #(.RAW_W(RAW_W), .OUT_W(OUT_W)) i_res (
        .clk     (clk),
        .rst     (rst),
        .load    (capture),
        .word_in (rd_word),
        .data_q  (data_out)
    );

endmodule

// File: rtl/adc_xfer_ctrl_chk.sv
module adc_xfer_ctrl_chk #(
    parameter int RAW_W = 16,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_sel,
    input logic             timer_pulse,
    input logic             manual_pulse,
    input logic             conv_start,
    input logic             eoc,
    input logic             rd_en,
    input logic             drdy,
    input logic [RAW_W-1:0] rd_word,
    input logic [OUT_W-1:0] data_out,
    input logic             write_stb
);

    localparam int LSB = RAW_W - OUT_W;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_out == '0 && !conv_start && !rd_en && !write_stb));

    // R3 is covered by the same property with auto_sel low
    p_trig_src_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(auto_sel ? timer_pulse : manual_pulse));

    p_conv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_rd_after_eoc_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> $past(eoc));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && data_out != $past(data_out)) |-> write_stb);

    p_write_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        write_stb |=> !write_stb);

    p_write_data_r7: assert property (@(posedge clk) disable iff (rst)
        write_stb |-> (data_out == $past(rd_word[RAW_W-1:LSB])));

    p_no_start_in_xmit_r8: assert property (@(posedge clk) disable iff (rst)
        write_stb |-> !conv_start);

endmodule

bind adc_xfer_ctrl adc_xfer_ctrl_chk #(.RAW_W(RAW_W), .OUT_W(OUT_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_sel     (auto_sel),
    .timer_pulse  (timer_pulse),
    .manual_pulse (manual_pulse),
    .conv_start   (conv_start),
    .eoc          (eoc),
    .rd_en        (rd_en),
    .drdy         (drdy),
    .rd_word      (rd_word),
    .data_out     (data_out),
    .write_stb    (write_stb)
);

// File: tb/test_adc_xfer_ctrl.sv
module test_adc_xfer_ctrl;

    localparam int RAW_W    = 16;
    localparam int OUT_W    = 12;
    localparam int SH       = RAW_W - OUT_W;
    localparam int EOC_LAT  = 5;
    localparam int RDY_LAT  = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             auto_sel = 1'b1;
    logic             timer_pulse = 1'b0;
    logic             manual_pulse = 1'b0;
    logic             conv_start;
    logic             eoc = 1'b0;
    logic             rd_en;
    logic             drdy = 1'b0;
    logic [RAW_W-1:0] rd_word = '0;
    logic [OUT_W-1:0] data_out;
    logic             write_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_xfer_ctrl #(.RAW_W(RAW_W), .OUT_W(OUT_W)) i_adc_xfer_ctrl (
        .clk          (clk),
        .rst          (rst),
        .auto_sel     (auto_sel),
        .timer_pulse  (timer_pulse),
        .manual_pulse (manual_pulse),
        .conv_start   (conv_start),
        .eoc          (eoc),
        .rd_en        (rd_en),
        .drdy         (drdy),
        .rd_word      (rd_word),
        .data_out     (data_out),
        .write_stb    (write_stb)
    );

    // Behavioural converter stub
    logic [RAW_W-1:0] stub_word = '0;
    int ecnt = 0;
    int rcnt = 0;
    always @(posedge clk) begin
        eoc  <= 1'b0;
        drdy <= 1'b0;
        if (conv_start) ecnt <= EOC_LAT;
        else if (ecnt != 0) begin
            ecnt <= ecnt - 1;
            if (ecnt == 1) eoc <= 1'b1;
        end
        if (rd_en) rcnt <= RDY_LAT;
        else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
            if (rcnt == 1) begin
                drdy    <= 1'b1;
                rd_word <= stub_word;
            end
        end
    end

    // Cycle counter and strobe monitor
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_conv = 0, n_rd = 0, n_wr = 0;
    int t_conv = 0, t_eoc = 0, t_rd = 0, t_drdy = 0, t_wr = 0;
    int wr_data = 0;
    always @(negedge clk) begin
        if (conv_start) begin n_conv++; t_conv = cyc; end
        if (rd_en)      begin n_rd++;   t_rd   = cyc; end
        if (eoc)        t_eoc  = cyc;
        if (drdy)       t_drdy = cyc;
        if (write_stb)  begin n_wr++; t_wr = cyc; wr_data = int'(data_out); end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig(input bit use_timer);
        @(negedge clk);
        if (use_timer) timer_pulse = 1'b1; else manual_pulse = 1'b1;
        @(negedge clk);
        timer_pulse  = 1'b0;
        manual_pulse = 1'b0;
    endtask

    task automatic do_xfer(input bit mode, input logic [RAW_W-1:0] word);
        int b_conv, b_wr, tc, guard;
        int exp_d;
        exp_d = int'(word >> SH);
        stub_word = word;
        @(negedge clk);
        auto_sel = mode;
        b_conv = n_conv;
        b_wr   = n_wr;
        @(negedge clk);
        tc = cyc;
        if (mode) timer_pulse = 1'b1; else manual_pulse = 1'b1;
        @(negedge clk);
        timer_pulse  = 1'b0;
        manual_pulse = 1'b0;
        // busy-time trigger on the selected source (R8)
        pulse_trig(mode);
        guard = 0;
        while (n_wr == b_wr && guard < 200) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        chk(guard < 200, "R7 write seen", guard, 0);
        chk(t_conv - tc == 1, "R4 conv_start offset", t_conv - tc, 1);
        chk(t_rd - t_eoc == 1, "R5 rd_en offset", t_rd - t_eoc, 1);
        chk(t_wr - t_drdy == 2, "R7 write offset", t_wr - t_drdy, 2);
        chk(wr_data == exp_d, "R6 data at write", wr_data, exp_d);
        chk(n_wr - b_wr == 1, "R7 writes per trigger", n_wr - b_wr, 1);
        chk(n_conv - b_conv == 1, "R8 starts per trigger", n_conv - b_conv, 1);
        chk(int'(data_out) == exp_d, "R6 data held", int'(data_out), exp_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int b_conv, b_wr, d0;
        logic [RAW_W-1:0] w;
        repeat (3) @(negedge clk);
        chk(data_out == '0 && !write_stb && !conv_start && !rd_en, "R1 during reset",
            int'(data_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(data_out == '0 && !write_stb && !conv_start && !rd_en, "R1 after reset",
            int'(data_out), 0);

        // R6 R7 sweep: edges and a spread of words in both modes
        for (int m = 0; m < 2; m++) begin
            do_xfer(m[0], 16'hFFFF);
            do_xfer(m[0], 16'h000F);
            do_xfer(m[0], 16'hFFF0);
            for (int i = 0; i < 40; i++) begin
                w = RAW_W'((i * 16'h0813) ^ (i << 11) ^ (m * 16'h5A5A));
                do_xfer(m[0], w);
            end
        end

        // R2: manual ignored in auto mode
        do_xfer(1'b1, 16'h1234);
        b_conv = n_conv; d0 = int'(data_out);
        auto_sel = 1'b1;
        pulse_trig(1'b0);
        repeat (15) @(negedge clk);
        chk(n_conv == b_conv, "R2 manual ignored", n_conv - b_conv, 0);
        chk(int'(data_out) == d0, "R2 data unchanged", int'(data_out), d0);

        // R3: timer ignored in manual mode
        auto_sel = 1'b0;
        pulse_trig(1'b1);
        repeat (15) @(negedge clk);
        chk(n_conv == b_conv, "R3 timer ignored", n_conv - b_conv, 0);
        chk(int'(data_out) == d0, "R3 data unchanged", int'(data_out), d0);

        // R9: reset in the middle of a transfer
        stub_word = 16'hABCD;
        b_wr = n_wr;
        b_conv = n_rd;
        pulse_trig(1'b0);
        while (n_rd == b_conv) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(data_out == '0, "R9 data cleared", int'(data_out), 0);
        chk(!conv_start && !rd_en && !write_stb, "R9 strobes low", int'(write_stb), 0);
        repeat (40) @(negedge clk);
        chk(n_wr == b_wr, "R9 no write after abort", n_wr - b_wr, 0);
        chk(data_out == '0, "R9 data stays cleared", int'(data_out), 0);
        do_xfer(1'b0, 16'h8421);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule